// File: doc/BRIEF.md
# Video Controller Register Snoop and Cell Write Port

This block sits on a CPU I/O bus next to the register file of a CRT timing controller. The controller takes two adjacent port addresses. An even-address write picks a register number and an odd-address write loads that register. The block keeps its own copy of the selected register number. It also watches data writes to the two registers that hold the display-update position, and from them it builds a 16-bit cell pointer.

A second pair of adjacent port addresses serves as the video write port. A CPU write to it does not carry a video address. The block computes the byte address from the snooped cell pointer: every character cell holds two bytes, so the address is pointer times two plus the port offset. It then drives a single-cycle write strobe toward a 64 KiB video RAM.

Reads on the controller ports return either a status byte or the contents of the selected stub register. The status byte carries an update-pending flag. The controller's own timing logic is not part of the block. A small register array stands in for it.

Top module: `crtc_vram_snoop`

## Requirements
- R1: A write to the controller index port (controller base address, bit 0 = 0) latches the 8-bit data as the current register number. The next data-port access uses that number.
- R2: A write to the controller data port (base address, bit 0 = 1) while the register number is 0x12 loads the data into the high byte of the cell pointer and leaves the low byte unchanged.
- R3: A data-port write while the register number is 0x13 loads the low byte of the cell pointer and leaves the high byte unchanged.
- R4: A data-port write to any other register number leaves the cell pointer unchanged.
- R5: A write to the video port (video base address plus offset 0 or 1) produces the RAM byte address (pointer × 2 + offset), truncated to 16 bits.
- R6: Each video-port write gives exactly one cycle of `vram_we` high, on the cycle after the bus write, with `vram_wdata` equal to the written byte. No other access raises `vram_we`.
- R7: A status read (index port address with `bus_rd` high) returns 0x80 while the update-pending flag is set and 0x00 otherwise. A data write to register 0x12 or 0x13 sets the flag. A video-port write clears it.
- R8: After reset the register number, the cell pointer, the pending flag and all stub registers are zero.
- R9: A data-port read returns the stub register selected by the low 5 bits of the register number. A data-port write stores into that same register.
- R10: Bus writes outside both port pairs change neither the register number, the stub registers, the pointer nor the pending flag. `bus_rdata` reads 0x00 when no controller port is being read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | CPU I/O address |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data from controller ports (combinational) |
| vram_we | output | 1 | Video RAM byte write enable |
| vram_addr | output | 16 | Video RAM byte address |
| vram_wdata | output | 8 | Video RAM write data |

## Verification
The hardest case to reach is the address wrap. The pointer must have its top bit set before the doubling drops that bit, and the pointer can only be loaded a byte at a time, through two indirect register writes. The bench therefore sweeps many high/low byte pairs through that two-step path. The sweep includes 0x80xx and 0xFFFF pointers, and for each pair it writes both port offsets. A separate phase writes registers next to 0x12 and 0x13 and then an index with bits above the stub's width. This shows that near-miss register numbers leave the pointer alone, while the stub's index masking still works.

// File: rtl/crtc_snoop_pkg.sv
package crtc_snoop_pkg;
  localparam logic [7:0] REG_PTR_HI = 8'h12;
  localparam logic [7:0] REG_PTR_LO = 8'h13;
  localparam logic [7:0] STAT_PEND  = 8'h80;

  // byte address of a two-byte cell, wrapped to 16 bits
  function automatic logic [15:0] cell_byte_addr(input logic [15:0] ptr, input logic off);
    logic [16:0] full;
    full = {ptr, 1'b0} + {16'd0, off};
    return full[15:0];
  endfunction
endpackage

// File: rtl/snoop_bus_decode.sv
module snoop_bus_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CTL_BASE = '0,
  parameter logic [ADDR_W-1:0] VID_BASE = 'h70
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              idx_wr,
  output logic              dat_wr,
  output logic              vid_wr,
  output logic              stat_rd,
  output logic              dat_rd,
  output logic              vid_off
);
  logic ctl_hit, vid_hit;
  assign ctl_hit = (addr[ADDR_W-1:1] == CTL_BASE[ADDR_W-1:1]);
  assign vid_hit = (addr[ADDR_W-1:1] == VID_BASE[ADDR_W-1:1]);
  assign idx_wr  = wr && ctl_hit && !addr[0];
  assign dat_wr  = wr && ctl_hit &&  addr[0];
  assign stat_rd = rd && ctl_hit && !addr[0];
  assign dat_rd  = rd && ctl_hit &&  addr[0];
  assign vid_wr  = wr && vid_hit;
  assign vid_off = addr[0];
endmodule

// File: rtl/ctl_reg_stub.sv
module ctl_reg_stub #(
  parameter int NREGS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic       dat_wr,
  input  logic [7:0] wdata,
  output logic [7:0] reg_num,
  output logic [7:0] reg_rdata
);
  localparam int IDX_W = $clog2(NREGS);
  logic [7:0] regs [NREGS];
  logic [IDX_W-1:0] sel;
  assign sel = reg_num[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_num <= '0;
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else begin
      if (idx_wr) reg_num <= wdata;
      if (dat_wr) regs[sel] <= wdata;
    end
  end
  assign reg_rdata = regs[sel];

  AST_IDX_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> reg_num == $past(wdata)); // R1
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_wr |=> $stable(reg_num)); // R10
endmodule

// File: rtl/ptr_snoop.sv
module ptr_snoop
  import crtc_snoop_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dat_wr,
  input  logic        vid_wr,
  input  logic [7:0]  reg_num,
  input  logic [7:0]  wdata,
  output logic [15:0] cell_ptr,
  output logic        pend
);
  logic hit_hi, hit_lo;
  assign hit_hi = dat_wr && (reg_num == REG_PTR_HI);
  assign hit_lo = dat_wr && (reg_num == REG_PTR_LO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cell_ptr <= '0;
      pend     <= 1'b0;
    end else begin
      if (hit_hi) cell_ptr[15:8] <= wdata;
      if (hit_lo) cell_ptr[7:0]  <= wdata;
      if (hit_hi || hit_lo) pend <= 1'b1;
      else if (vid_wr)      pend <= 1'b0;
    end
  end

  AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    hit_hi |=> cell_ptr[7:0] == $past(cell_ptr[7:0])); // R2
  AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    hit_lo |=> cell_ptr[15:8] == $past(cell_ptr[15:8])); // R3
  AST_OTHER_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && reg_num != REG_PTR_HI && reg_num != REG_PTR_LO) |=> $stable(cell_ptr)); // R4
  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_wr && !dat_wr) |=> !pend); // R7
endmodule

// File: rtl/vram_wr_gen.sv
module vram_wr_gen
  import crtc_snoop_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        vid_wr,
  input  logic        vid_off,
  input  logic [15:0] cell_ptr,
  input  logic [7:0]  wdata,
  output logic        we,
  output logic [15:0] addr,
  output logic [7:0]  data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we   <= 1'b0;
      addr <= '0;
      data <= '0;
    end else begin
      we <= vid_wr;
      if (vid_wr) begin
        addr <= cell_byte_addr(cell_ptr, vid_off);
        data <= wdata;
      end
    end
  end

  AST_WE_FROM_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> $past(vid_wr)); // R6
  AST_ADDR_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> addr[0] == $past(vid_off)); // R5
endmodule

// File: rtl/crtc_vram_snoop.sv
module crtc_vram_snoop
  import crtc_snoop_pkg::*;
#(
  parameter int NREGS = 32,
  parameter logic [15:0] CTL_BASE = 16'h0000,
  parameter logic [15:0] VID_BASE = 16'h0070
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        vram_we,
  output logic [15:0] vram_addr,
  output logic [7:0]  vram_wdata
);
  logic idx_wr, dat_wr, vid_wr, stat_rd, dat_rd, vid_off, pend;
  logic [7:0]  reg_num, reg_rdata;
  logic [15:0] cell_ptr;

  snoop_bus_decode #(.ADDR_W(16), .CTL_BASE(CTL_BASE), .VID_BASE(VID_BASE)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .idx_wr(idx_wr), .dat_wr(dat_wr),
    .vid_wr(vid_wr), .stat_rd(stat_rd), .dat_rd(dat_rd), .vid_off(vid_off));

  ctl_reg_stub #(.NREGS(NREGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .dat_wr(dat_wr), .wdata(bus_wdata),
    .reg_num(reg_num), .reg_rdata(reg_rdata));

  ptr_snoop u_ptr (
    .clk(clk), .rst_n(rst_n), .dat_wr(dat_wr), .vid_wr(vid_wr), .reg_num(reg_num),
    .wdata(bus_wdata), .cell_ptr(cell_ptr), .pend(pend));

  vram_wr_gen u_vwr (
    .clk(clk), .rst_n(rst_n), .vid_wr(vid_wr), .vid_off(vid_off), .cell_ptr(cell_ptr),
    .wdata(bus_wdata), .we(vram_we), .addr(vram_addr), .data(vram_wdata));

  always_comb begin
    if (stat_rd)     bus_rdata = pend ? STAT_PEND : 8'h00;
    else if (dat_rd) bus_rdata = reg_rdata;
    else             bus_rdata = 8'h00;
  end

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    vram_we && !vid_wr |=> !vram_we); // R6
  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && (reg_num == REG_PTR_HI || reg_num == REG_PTR_LO)) |=> pend); // R7
endmodule

// File: tb/crtc_vram_snoop_bench.sv
module crtc_vram_snoop_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic vram_we;
  logic [15:0] vram_addr;
  logic [7:0] vram_wdata;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  crtc_vram_snoop u_crtc_vram_snoop (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vram_we(vram_we),
    .vram_addr(vram_addr), .vram_wdata(vram_wdata));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bus write; returns at the negedge after the capturing edge
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic set_ptr(input logic [7:0] hi, input logic [7:0] lo);
    wr(16'h0000, 8'h12); wr(16'h0001, hi);
    wr(16'h0000, 8'h13); wr(16'h0001, lo);
  endtask

  // video write; check the strobe cycle and the cycle after
  task automatic vid(input logic off, input logic [7:0] d, input logic [15:0] exp_a, input string req);
    wr(16'h0070 | {15'd0, off}, d);
    chk("R6 we", {31'd0, vram_we}, 32'd1);
    chk(req, {16'd0, vram_addr}, {16'd0, exp_a});
    chk("R6 data", {24'd0, vram_wdata}, {24'd0, d});
    @(negedge clk);
    chk("R6 single", {31'd0, vram_we}, 32'd0);
  endtask

  function automatic logic [15:0] ref_addr(input logic [7:0] hi, input logic [7:0] lo, input logic off);
    int v;
    v = ((int'(hi) * 256 + int'(lo)) * 2 + int'(off)) % 65536;
    return v[15:0];
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state
    chk("R8 we", {31'd0, vram_we}, 32'd0);
    rd(16'h0000, r); chk("R8 status", {24'd0, r}, 32'h00);
    rd(16'h0001, r); chk("R8 reg0", {24'd0, r}, 32'h00);
    vid(1'b0, 8'hAA, 16'h0000, "R8 ptr zero");
    // R7 flag
    wr(16'h0000, 8'h12); wr(16'h0001, 8'h01);
    rd(16'h0000, r); chk("R7 set hi", {24'd0, r}, 32'h80);
    vid(1'b1, 8'h5A, 16'h0201, "R2 hi only");
    rd(16'h0000, r); chk("R7 cleared", {24'd0, r}, 32'h00);
    wr(16'h0000, 8'h13); wr(16'h0001, 8'h40);
    rd(16'h0000, r); chk("R7 set lo", {24'd0, r}, 32'h80);
    vid(1'b0, 8'h11, 16'h0280, "R3 lo keeps hi");
    // R2/R3/R5 sweep
    for (int i = 0; i < 24; i++) begin
      logic [7:0] hi, lo;
      hi = 8'((i * 23 + 7) % 256);
      lo = 8'((i * 41 + 3) % 256);
      if (i == 22) begin hi = 8'hFF; lo = 8'hFF; end
      if (i == 23) begin hi = 8'h80; lo = 8'h01; end
      set_ptr(hi, lo);
      vid(1'b0, 8'(i), ref_addr(hi, lo, 1'b0), "R5 off0");
      vid(1'b1, 8'(i + 100), ref_addr(hi, lo, 1'b1), "R5 off1");
    end
    // R3 replaces only low byte
    wr(16'h0000, 8'h13); wr(16'h0001, 8'hC4);
    vid(1'b0, 8'h01, ref_addr(8'h80, 8'hC4, 1'b0), "R3 low replace");
    // R4 neighbour registers
    wr(16'h0000, 8'h11); wr(16'h0001, 8'h99);
    wr(16'h0000, 8'h14); wr(16'h0001, 8'h77);
    rd(16'h0000, r); chk("R4 no pend", {24'd0, r}, 32'h00);
    vid(1'b1, 8'h02, ref_addr(8'h80, 8'hC4, 1'b1), "R4 ptr held");
    // R1/R9 register stub
    wr(16'h0000, 8'h05); wr(16'h0001, 8'h3C);
    wr(16'h0000, 8'h07); wr(16'h0001, 8'h55);
    rd(16'h0001, r); chk("R1 idx7", {24'd0, r}, 32'h55);
    wr(16'h0000, 8'h05);
    rd(16'h0001, r); chk("R1 idx5", {24'd0, r}, 32'h3C);
    wr(16'h0000, 8'h25);
    rd(16'h0001, r); chk("R9 masked", {24'd0, r}, 32'h3C);
    wr(16'h0000, 8'h32);
    rd(16'h0001, r); chk("R9 reg18 mirror", {24'd0, r}, 32'h80);
    rd(16'h0000, r); chk("R9 no pend alias", {24'd0, r}, 32'h00);
    // R10 stray writes
    wr(16'h0000, 8'h07);
    wr(16'h0050, 8'h12);
    chk("R10 no we", {31'd0, vram_we}, 32'd0);
    wr(16'h0003, 8'hEE);
    rd(16'h0001, r); chk("R10 reg kept", {24'd0, r}, 32'h55);
    rd(16'h0000, r); chk("R10 no pend", {24'd0, r}, 32'h00);
    rd(16'h0072, r); chk("R10 rdata idle", {24'd0, r}, 32'h00);
    vid(1'b0, 8'h03, ref_addr(8'h80, 8'hC4, 1'b0), "R10 ptr kept");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule